// File: doc/BRIEF.md
# Per-Bit Skew Result Normalizer

This block turns the raw results of a per-bit skew search on one byte lane into the values a calibration sequence programs. It takes eight 5-bit raw skew results, a per-bit engine-failure mask and the lane's lock flag. From these it forms normalized per-bit skews, in which the earliest bit becomes zero. It also produces a DQS centering adjustment equal to half the lane's skew spread. Finally it estimates the delay of one skew tap: the delay-line span of the lane, scaled by the delay-line tap period, divided by the skew spread.

A calibration sequencer runs the block once per lane and pass. In a receive pass the DQS adjustment is not issued. It is kept in a small table indexed by lane and chip select. In the following transmit pass for the same lane and chip select, the block issues both its own transmit adjustment and the kept receive adjustment. The tap estimate comes from a sequential restoring divider, so each result is announced by a one-cycle valid pulse a fixed number of cycles after start.

Top module: `skew_normalizer`

## Requirements
- R1: After reset `valid_o` is 0, all result outputs are 0, and every kept receive adjustment is 0. A transmit pass on a lane and chip select with no receive pass since reset returns `dqs_rx_o` = 0.
- R2: For a locked lane, `norm_o` bits [5i+4:5i] equal the effective result of bit i minus the lane minimum. The lane minimum is the smallest result among bits whose failure flag is clear, or 31 when every bit has failed.
- R3: A bit with its flag set in `bit_fail_i` has effective result 31. That value counts toward the lane maximum but never toward the lane minimum.
- R4: When `lock_i` is 0, `fail_o` is 1, every normalized value is 0, the lane maximum and minimum are taken as 0, `dqs_tx_o` is 0 and `tap_delay_o` equals `TYP_TAP`.
- R5: In a transmit pass (`tx_mode_i` = 1), `dqs_tx_o` equals (lane maximum − lane minimum) / 2, rounded down.
- R6: When the skew spread (maximum − minimum) is nonzero, `tap_delay_o` = floor(span × `tap_period_i` / spread). The span is `dl_max_i` − `dl_min_i`, taken as 0 when `dl_max_i` < `dl_min_i`.
- R7: When the skew spread is zero, `tap_delay_o` equals the parameter `TYP_TAP`.
- R8: In a receive pass (`tx_mode_i` = 0), `dqs_tx_o` and `dqs_rx_o` are 0. The adjustment (spread / 2, or 0 when unlocked) is kept for entry `lane_i` × `NCS` + `cs_i`, replacing the earlier value.
- R9: In a transmit pass, `dqs_rx_o` returns the adjustment last kept for the same lane and chip select. Other entries are unaffected.
- R10: `valid_o` is a one-cycle pulse, high in the `NUM_W`+2-th cycle after the cycle in which `start_i` is accepted. A `start_i` that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a run with the current inputs (taken when idle) |
| tx_mode_i | input | 1 | 1 = transmit pass, 0 = receive pass |
| lock_i | input | 1 | Lane locked during the search |
| lane_i | input | LANE_W (4) | Byte lane index |
| cs_i | input | CS_W (2) | Chip select index |
| raw_i | input | NBIT*RES_W (40) | Raw results, bit i at [5i+4:5i] |
| bit_fail_i | input | NBIT (8) | Per-bit engine failure flags |
| dl_max_i | input | DL_W (6) | Lane delay-line maximum |
| dl_min_i | input | DL_W (6) | Lane delay-line minimum |
| tap_period_i | input | TAP_W (10) | Delay-line tap period |
| valid_o | output | 1 | One-cycle result strobe |
| fail_o | output | 1 | Lane was not locked |
| norm_o | output | NBIT*RES_W (40) | Normalized per-bit skews |
| dqs_tx_o | output | RES_W-1 (4) | Transmit DQS adjustment |
| dqs_rx_o | output | RES_W-1 (4) | Kept receive DQS adjustment |
| tap_delay_o | output | DL_W+TAP_W (16) | Estimated skew-tap delay |

## Verification
The hardest situation to reach from the ports is a receive adjustment crossing from one pass to a later one. Only a transmit pass on the same lane and chip select reveals it, so an overwrite, a wrong index or a missing reset is invisible within a single run. The stimulus pairs directed receive and transmit passes on chosen entries, reads a neighbouring chip select to show it untouched, and resets in mid-run to show the table clears. Random runs mix both modes across all entries against a bench-held model of the table. The other rare cases are a start pulse inside a running division, an all-failed lane and an inverted delay-line span. Each is driven directly.

// File: rtl/nrm_pkg.sv
package nrm_pkg;

  typedef enum logic {
    NRM_IDLE = 1'b0,
    NRM_DIV  = 1'b1
  } nrm_state_e;

endpackage

// File: rtl/nrm_skew_reduce.sv
module nrm_skew_reduce #(
  parameter int NBIT  = 8,
  parameter int RES_W = 5
) (
  input  logic                  lock_i,
  input  logic [NBIT*RES_W-1:0] raw_i,
  input  logic [NBIT-1:0]       fail_i,
  output logic [NBIT*RES_W-1:0] norm_o,
  output logic [RES_W-1:0]      max_o,
  output logic [RES_W-1:0]      min_o
);

  localparam logic [RES_W-1:0] RES_TOP = '1;

  logic [RES_W-1:0] eff [NBIT];
  logic [RES_W-1:0] mx, mn;

  // effective value: failed bits pinned to the top code
  always_comb begin
    for (int i = 0; i < NBIT; i++) begin
      eff[i] = fail_i[i] ? RES_TOP : raw_i[i*RES_W +: RES_W];
    end
  end

  // running extremes; minimum sees passing bits only
  always_comb begin
    mx = '0;
    mn = RES_TOP;
    for (int i = 0; i < NBIT; i++) begin
      if (eff[i] > mx) mx = eff[i];
      if (!fail_i[i] && eff[i] < mn) mn = eff[i];
    end
  end

  always_comb begin
    norm_o = '0;
    max_o  = '0;
    min_o  = '0;
    if (lock_i) begin
      max_o = mx;
      min_o = mn;
      for (int i = 0; i < NBIT; i++) begin
        norm_o[i*RES_W +: RES_W] = eff[i] - mn;
      end
    end
  end

endmodule

// File: rtl/nrm_divider.sv
module nrm_divider #(
  parameter int NUM_W = 16,
  parameter int DEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);

  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(NUM_W);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W:0]   shifted;
  logic [DEN_W:0]   diff;
  logic             take;

  always_comb begin
    shifted = {rem_q, quo_q[NUM_W-1]};
    diff    = shifted - {1'b0, den_q};
    take    = (shifted >= {1'b0, den_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        quo_q  <= num_i;
        rem_q  <= '0;
        den_q  <= den_i;
        cnt_q  <= CNT_LOAD;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        quo_q <= {quo_q[NUM_W-2:0], take};
        rem_q <= take ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = quo_q;

  // partial remainder always stays below the divisor while iterating
  p_rem_below_div_r6: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (rem_q < den_q));

  // completion is a single strobe
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

// File: rtl/nrm_adj_store.sv
module nrm_adj_store #(
  parameter int DEPTH = 36,
  parameter int AW    = 6,
  parameter int DW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i && (int'(waddr_i) < DEPTH)) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (int'(raddr_i) < DEPTH) begin
      rdata_o <= mem[raddr_i];
    end else begin
      rdata_o <= '0;
    end
  end

  // a write lands in the table by the next read of the same entry
  p_write_visible_r8: assert property (@(posedge clk) disable iff (rst)
    (we_i && (int'(waddr_i) < DEPTH) && raddr_i == waddr_i) ##1 (raddr_i == $past(raddr_i))
      |=> (rdata_o == $past(wdata_i, 2)));

endmodule

// File: rtl/skew_normalizer.sv
module skew_normalizer #(
  parameter int NBIT    = 8,
  parameter int RES_W   = 5,
  parameter int NLANE   = 9,
  parameter int NCS     = 4,
  parameter int LANE_W  = 4,
  parameter int CS_W    = 2,
  parameter int DL_W    = 6,
  parameter int TAP_W   = 10,
  parameter int TYP_TAP = 14
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic                      tx_mode_i,
  input  logic                      lock_i,
  input  logic [LANE_W-1:0]         lane_i,
  input  logic [CS_W-1:0]           cs_i,
  input  logic [NBIT*RES_W-1:0]     raw_i,
  input  logic [NBIT-1:0]           bit_fail_i,
  input  logic [DL_W-1:0]           dl_max_i,
  input  logic [DL_W-1:0]           dl_min_i,
  input  logic [TAP_W-1:0]          tap_period_i,
  output logic                      valid_o,
  output logic                      fail_o,
  output logic [NBIT*RES_W-1:0]     norm_o,
  output logic [RES_W-2:0]          dqs_tx_o,
  output logic [RES_W-2:0]          dqs_rx_o,
  output logic [DL_W+TAP_W-1:0]     tap_delay_o
);

  import nrm_pkg::*;

  localparam int NUM_W = DL_W + TAP_W;
  localparam int ADJ_W = RES_W - 1;
  localparam int DEPTH = NLANE * NCS;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [NUM_W-1:0] TYP_Q = NUM_W'(TYP_TAP);

  // ---------------- reduction of the raw results
  logic [NBIT*RES_W-1:0] norm_c;
  logic [RES_W-1:0]      smax_c, smin_c;

  nrm_skew_reduce #(.NBIT(NBIT), .RES_W(RES_W)) u_reduce (
    .lock_i (lock_i),
    .raw_i  (raw_i),
    .fail_i (bit_fail_i),
    .norm_o (norm_c),
    .max_o  (smax_c),
    .min_o  (smin_c)
  );

  // ---------------- span, product, entry index
  logic [DL_W-1:0]  span_c;
  logic [NUM_W-1:0] prod_c;
  logic [AW-1:0]    addr_c;

  always_comb begin
    span_c = (dl_max_i > dl_min_i) ? (dl_max_i - dl_min_i) : '0;
    prod_c = NUM_W'(span_c) * NUM_W'(tap_period_i);
    addr_c = AW'(int'(lane_i) * NCS + int'(cs_i));
  end

  // ---------------- captured run context
  nrm_state_e            state_q;
  logic [NBIT*RES_W-1:0] norm_q;
  logic [RES_W-1:0]      den_q;
  logic [ADJ_W-1:0]      adj_q;
  logic [NUM_W-1:0]      num_q;
  logic [AW-1:0]         addr_q;
  logic                  mode_q;
  logic                  fail_q;
  logic                  go_q;

  logic                  div_done;
  logic [NUM_W-1:0]      div_quot;
  logic [RES_W-1:0]      div_den;
  logic [ADJ_W-1:0]      rx_rd;
  logic                  store_we;

  always_comb begin
    div_den  = (den_q == '0) ? RES_W'(1) : den_q;
    store_we = (state_q == NRM_DIV) && div_done && !mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= NRM_IDLE;
      norm_q  <= '0;
      den_q   <= '0;
      adj_q   <= '0;
      num_q   <= '0;
      addr_q  <= '0;
      mode_q  <= 1'b0;
      fail_q  <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      go_q <= 1'b0;
      case (state_q)
        NRM_IDLE: begin
          if (start_i) begin
            logic [RES_W-1:0] spread;
            spread  = smax_c - smin_c;
            norm_q  <= norm_c;
            den_q   <= spread;
            adj_q   <= ADJ_W'(spread >> 1);
            num_q   <= prod_c;
            addr_q  <= addr_c;
            mode_q  <= tx_mode_i;
            fail_q  <= !lock_i;
            go_q    <= 1'b1;
            state_q <= NRM_DIV;
          end
        end
        NRM_DIV: begin
          if (div_done) state_q <= NRM_IDLE;
        end
        default: state_q <= NRM_IDLE;
      endcase
    end
  end

  // ---------------- tap estimate divider
  nrm_divider #(.NUM_W(NUM_W), .DEN_W(RES_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .go_i   (go_q),
    .num_i  (num_q),
    .den_i  (div_den),
    .done_o (div_done),
    .quot_o (div_quot)
  );

  // ---------------- kept receive adjustments
  nrm_adj_store #(.DEPTH(DEPTH), .AW(AW), .DW(ADJ_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we_i    (store_we),
    .waddr_i (addr_q),
    .wdata_i (adj_q),
    .raddr_i (addr_q),
    .rdata_o (rx_rd)
  );

  // ---------------- registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o     <= 1'b0;
      fail_o      <= 1'b0;
      norm_o      <= '0;
      dqs_tx_o    <= '0;
      dqs_rx_o    <= '0;
      tap_delay_o <= '0;
    end else begin
      valid_o <= 1'b0;
      if (state_q == NRM_DIV && div_done) begin
        valid_o     <= 1'b1;
        fail_o      <= fail_q;
        norm_o      <= norm_q;
        dqs_tx_o    <= mode_q ? adj_q : '0;
        dqs_rx_o    <= mode_q ? rx_rd : '0;
        tap_delay_o <= (den_q == '0) ? TYP_Q : div_quot;
      end
    end
  end

  // ---------------- assertions
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == NRM_DIV && start_i) |=> ($stable(norm_q) && $stable(addr_q) && $stable(mode_q)));

  p_unlocked_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_o && fail_o) |-> (norm_o == '0 && dqs_tx_o == '0 && tap_delay_o == TYP_Q));

  p_rx_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !mode_q) |-> (dqs_tx_o == '0 && dqs_rx_o == '0));

  p_typical_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_o && den_q == '0) |-> (tap_delay_o == TYP_Q));

  p_adj_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_o && mode_q) |-> (dqs_tx_o == ADJ_W'(den_q >> 1)));

endmodule

// File: tb/skew_normalizer_bench.sv
module skew_normalizer_bench;

  localparam int NBIT = 8, RES_W = 5, NCS = 4, NLANE = 9, TYP = 14;
  localparam int NUM_W = 16;

  logic clk = 1'b0;
  logic rst;
  logic start, txm, lock;
  logic [3:0] lane;
  logic [1:0] cs;
  logic [39:0] raw;
  logic [7:0] bfail;
  logic [5:0] dlmax, dlmin;
  logic [9:0] tper;
  logic valid, failo;
  logic [39:0] norm;
  logic [3:0] dtx, drx;
  logic [15:0] tapd;

  int tests = 0, fails = 0;
  logic [3:0] mdl [NLANE*NCS];

  always #4 clk = ~clk;

  skew_normalizer u_skew_normalizer (
    .clk(clk), .rst(rst), .start_i(start), .tx_mode_i(txm), .lock_i(lock),
    .lane_i(lane), .cs_i(cs), .raw_i(raw), .bit_fail_i(bfail),
    .dl_max_i(dlmax), .dl_min_i(dlmin), .tap_period_i(tper),
    .valid_o(valid), .fail_o(failo), .norm_o(norm), .dqs_tx_o(dtx),
    .dqs_rx_o(drx), .tap_delay_o(tapd)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NLANE*NCS; i++) mdl[i] = '0;
    @(negedge clk);
  endtask

  task automatic run(input logic md, input logic lk, input int ln, input int c,
                     input logic [39:0] rw, input logic [7:0] fm,
                     input logic [5:0] dmx, input logic [5:0] dmn,
                     input logic [9:0] tp, input bit interfere, input string tag);
    logic [4:0] e [NBIT];
    logic [4:0] mx, mn;
    logic [39:0] nexp;
    logic [3:0] adj, txe, rxe;
    logic [15:0] texp;
    int span, idx, n;
    mx = 0; mn = 31;
    for (int i = 0; i < NBIT; i++) begin
      e[i] = fm[i] ? 5'd31 : rw[i*5 +: 5];
      if (e[i] > mx) mx = e[i];
      if (!fm[i] && e[i] < mn) mn = e[i];
    end
    nexp = '0;
    if (lk) for (int i = 0; i < NBIT; i++) nexp[i*5 +: 5] = e[i] - mn;
    else begin mx = 0; mn = 0; end
    adj = 4'((mx - mn) / 2);
    span = (dmx > dmn) ? int'(dmx) - int'(dmn) : 0;
    texp = (mx == mn) ? 16'(TYP) : 16'((span * int'(tp)) / int'(mx - mn));
    idx = ln * NCS + c;
    txe = md ? adj : 4'd0;
    rxe = md ? mdl[idx] : 4'd0;
    if (!md) mdl[idx] = adj;

    txm = md; lock = lk; lane = 4'(ln); cs = 2'(c); raw = rw; bfail = fm;
    dlmax = dmx; dlmin = dmn; tper = tp; start = 1'b1;
    @(negedge clk);
    start = 1'b0; n = 1;
    if (interfere) begin
      @(negedge clk); n++;
      raw = ~rw; lock = ~lk; txm = ~md; lane = 4'((ln + 1) % NLANE); start = 1'b1;
      @(negedge clk); n++;
      start = 1'b0;
    end
    while (!valid && n < 200) begin
      @(negedge clk); n++;
    end
    chk(n == NUM_W + 3, "R10", {tag, " latency"}, 64'(n), 64'(NUM_W + 3));
    chk(norm == nexp, lk ? "R2" : "R4", {tag, " norm"}, 64'(norm), 64'(nexp));
    chk(failo == !lk, "R4", {tag, " fail"}, 64'(failo), 64'(!lk));
    chk(dtx == txe, md ? "R5" : "R8", {tag, " dqs_tx"}, 64'(dtx), 64'(txe));
    chk(drx == rxe, md ? "R9" : "R8", {tag, " dqs_rx"}, 64'(drx), 64'(rxe));
    chk(tapd == texp, (mx == mn) ? "R7" : "R6", {tag, " tap"}, 64'(tapd), 64'(texp));
    @(negedge clk);
    chk(valid == 1'b0, "R10", {tag, " pulse"}, 64'(valid), 64'd0);
  endtask

  function automatic logic [39:0] pack(input int a0, a1, a2, a3, a4, a5, a6, a7);
    return {5'(a7), 5'(a6), 5'(a5), 5'(a4), 5'(a3), 5'(a2), 5'(a1), 5'(a0)};
  endfunction

  initial begin
    #1600000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    txm = 0; lock = 0; lane = 0; cs = 0; raw = 0; bfail = 0;
    dlmax = 0; dlmin = 0; tper = 0;
    do_reset();
    // R1 reset state at the ports
    chk(valid == 1'b0, "R1", "valid after reset", 64'(valid), 0);
    chk({norm, dtx, drx, tapd, failo} == '0, "R1", "outputs after reset",
        64'({dtx, drx, tapd}), 0);
    run(1, 1, 0, 0, pack(3, 9, 4, 12, 7, 5, 3, 8), 8'h00, 40, 10, 300, 0, "R1 fresh tx");
    // R7 flat results
    run(1, 1, 1, 0, pack(10, 10, 10, 10, 10, 10, 10, 10), 8'h00, 50, 5, 200, 0, "R7 flat");
    // R4 unlocked receive then transmit on the same entry
    run(0, 0, 2, 1, pack(1, 20, 5, 9, 3, 30, 2, 6), 8'h00, 30, 2, 100, 0, "R4 unlocked");
    run(1, 1, 2, 1, pack(4, 6, 4, 8, 4, 5, 7, 4), 8'h00, 30, 2, 100, 0, "R4 follow tx");
    // R8/R9 keep, read back, neighbour untouched, overwrite
    run(0, 1, 3, 2, pack(2, 19, 5, 11, 2, 7, 13, 4), 8'h00, 33, 1, 77, 0, "R8 rx keep");
    run(1, 1, 3, 1, pack(5, 6, 7, 8, 9, 10, 11, 12), 8'h00, 20, 0, 64, 0, "R9 other cs");
    run(1, 1, 3, 2, pack(5, 6, 7, 8, 9, 10, 11, 12), 8'h00, 20, 0, 64, 0, "R9 read back");
    run(0, 1, 3, 2, pack(0, 2, 0, 1, 0, 2, 0, 1), 8'h00, 20, 0, 64, 0, "R8 overwrite");
    run(1, 1, 3, 2, pack(0, 2, 0, 1, 0, 2, 0, 1), 8'h00, 20, 0, 64, 0, "R9 after overwrite");
    // R3 failed bits
    run(1, 1, 4, 0, pack(6, 8, 0, 9, 7, 6, 8, 9), 8'h0C, 63, 0, 1023, 0, "R3 some failed");
    run(1, 1, 4, 3, pack(1, 2, 3, 4, 5, 6, 7, 8), 8'hFF, 63, 0, 1023, 0, "R3 all failed");
    // R6 extremes and inverted span
    run(1, 1, 5, 0, pack(0, 31, 16, 8, 4, 2, 1, 30), 8'h00, 63, 0, 1023, 0, "R6 wide");
    run(1, 1, 5, 1, pack(0, 3, 1, 2, 0, 3, 1, 2), 8'h00, 4, 50, 600, 0, "R6 inverted span");
    // R10 start while running
    run(1, 1, 6, 0, pack(9, 3, 14, 6, 3, 8, 5, 11), 8'h01, 45, 12, 333, 1, "R10 busy start");
    // R1 reset clears kept values
    run(0, 1, 7, 3, pack(0, 30, 0, 30, 0, 30, 0, 30), 8'h00, 10, 1, 9, 0, "R1 pre-reset rx");
    do_reset();
    run(1, 1, 7, 3, pack(1, 2, 1, 2, 1, 2, 1, 2), 8'h00, 10, 1, 9, 0, "R1 post-reset tx");
    // random mix
    for (int k = 0; k < 160; k++) begin
      logic [39:0] rr;
      logic [7:0] fm;
      int base, sp;
      base = $urandom_range(0, 20);
      sp = $urandom_range(0, 11);
      for (int i = 0; i < NBIT; i++) rr[i*5 +: 5] = 5'(base + $urandom_range(0, sp));
      fm = ($urandom_range(0, 4) == 0) ? 8'($urandom) : 8'h00;
      run(1'($urandom_range(0, 1)), ($urandom_range(0, 9) != 0),
          $urandom_range(0, NLANE - 1), $urandom_range(0, NCS - 1), rr, fm,
          6'($urandom), 6'($urandom), 10'($urandom), ($urandom_range(0, 15) == 0),
          "R2 random");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule